// File: doc/BRIEF.md
# Boot Mode Stall Controller

This block sequences processor start-up after a hard reset. An active-low reset input feeds a short synchronizer that produces the internal reset for the rest of the system. In the cycle the internal reset releases, the block samples a two-bit boot mode. The processor core is then held stalled while the rest of the system runs.

The stall ends in a way that depends on the sampled mode:

- **Host boot:** the stall ends when an external host sets the interrupt bit of its control register through a simple write port.
- **Emulation boot:** the stall ends on a request from a debug emulator. That request also sets the interrupt bit if it is still clear.
- **ROM boot:** the block pulses a copy-start output to an external block copier, and the stall ends when the copier reports completion.

The host interrupt bit is also the run-time interrupt from host to core. A set that arrives while the core is stalled is not delivered as a core interrupt. Once the core runs, a new interrupt can only be raised after the core has cleared the bit. In every mode the core begins execution at a fixed start address, zero by default.

Top module: `boot_stall_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is 0, `cpu_stall` is 1, and `host_int_flag`, `copy_start`, `run_start` and `cpu_int` are all 0. `sys_rst_n` rises after the RST_SYNC-th rising clock edge following the release of `rst_n`.
- R2: `boot_mode` is captured at the first rising edge on which `sys_rst_n` is high, and later changes have no effect. The encodings are 2'b00 host, 2'b01 emulation, 2'b10 ROM, and 2'b11 behaves as host.
- R3: In host mode, `cpu_stall` stays 1 until a host write carries 1 in bit INT_BIT of `host_wdata`. A write with that bit at 0 has no effect. After the qualifying write edge, `cpu_stall` is 0 and `run_start` is 1 for exactly one cycle.
- R4: In emulation mode and in ROM mode, a host write that sets the interrupt bit sets `host_int_flag` but leaves `cpu_stall` at 1.
- R5: A host interrupt bit set while the core is stalled never produces a `cpu_int` pulse.
- R6: While running, a host set while `host_int_flag` is 1 produces no `cpu_int`. `cpu_clr_int` clears the flag. A host set while the flag is 0 sets it and gives a one-cycle `cpu_int` pulse after that edge.
- R7: In emulation mode, `emu_req` during the stall ends the stall and sets `host_int_flag`. If the flag is already set, it is left set.
- R8: In ROM mode only, `copy_start` is high for exactly the one cycle after the mode-capture edge. The stall is held until `copy_done`, after which `cpu_stall` is 0 and `run_start` pulses once.
- R9: `boot_addr` always equals BOOT_ADDR (zero by default), whatever the mode.
- R10: `emu_req` outside emulation mode and `copy_done` outside ROM mode do not release the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| boot_mode | input | 2 | Boot mode selection, sampled once |
| host_wr | input | 1 | Host control register write strobe |
| host_wdata | input | CTRL_W | Host write data; bit INT_BIT is the interrupt bit |
| emu_req | input | 1 | Emulator release request |
| copy_done | input | 1 | Block copier completion pulse |
| cpu_clr_int | input | 1 | Core clears the host interrupt bit |
| sys_rst_n | output | 1 | Synchronized internal reset, active low |
| cpu_stall | output | 1 | Core stall |
| run_start | output | 1 | One-cycle pulse when the stall ends |
| cpu_int | output | 1 | One-cycle host interrupt to the running core |
| host_int_flag | output | 1 | Current host interrupt bit |
| copy_start | output | 1 | One-cycle request to the block copier |
| boot_addr | output | ADDR_W | Execution start address |

## Verification
The bench builds the block with RST_SYNC=3, CTRL_W=16 and INT_BIT=5. This makes the three-stage internal reset delay observable edge by edge. It also puts the interrupt bit away from bit 0, so writes that set only the other bits reach the no-effect case of R3. Every mode, including the reserved code, is entered through a fresh reset. In each mode, the release inputs meant for the other modes are applied before the valid one.

// File: rtl/boot_stall_ctrl.sv
module boot_stall_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int CTRL_W   = 8,
  parameter int INT_BIT  = 0,
  parameter int RST_SYNC = 2,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_mode,
  input  logic              host_wr,
  input  logic [CTRL_W-1:0] host_wdata,
  input  logic              emu_req,
  input  logic              copy_done,
  input  logic              cpu_clr_int,
  output logic              sys_rst_n,
  output logic              cpu_stall,
  output logic              run_start,
  output logic              cpu_int,
  output logic              host_int_flag,
  output logic              copy_start,
  output logic [ADDR_W-1:0] boot_addr
);

  localparam logic [1:0] M_HOST = 2'b00;
  localparam logic [1:0] M_EMU  = 2'b01;
  localparam logic [1:0] M_ROM  = 2'b10;

  // RST_SYNC must be at least 2
  logic [RST_SYNC-1:0] sync_q;
  logic       armed_q, run_q, flag_q, busy_q, start_q, int_q, cstart_q;
  logic [1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[RST_SYNC-2:0], 1'b1};

  assign sys_rst_n = sync_q[RST_SYNC-1];

  logic latch_now, set_req, host_set, stalled, is_host, emu_go, host_go, rom_go, go;

  assign latch_now = sys_rst_n & ~armed_q;
  assign set_req   = host_wr & host_wdata[INT_BIT];
  assign host_set  = set_req & ~flag_q;
  assign stalled   = armed_q & ~run_q;
  assign is_host   = (mode_q == M_HOST) | (mode_q == 2'b11);
  assign host_go   = stalled & is_host & set_req;
  assign emu_go    = stalled & (mode_q == M_EMU) & emu_req;
  assign rom_go    = stalled & (mode_q == M_ROM) & busy_q & copy_done;
  assign go        = host_go | emu_go | rom_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !sys_rst_n) begin
      armed_q  <= 1'b0;
      mode_q   <= M_HOST;
      run_q    <= 1'b0;
      flag_q   <= 1'b0;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      int_q    <= 1'b0;
      cstart_q <= 1'b0;
    end else begin
      if (latch_now) begin
        armed_q <= 1'b1;
        mode_q  <= boot_mode;
      end
      cstart_q <= latch_now & (boot_mode == M_ROM);
      if (latch_now & (boot_mode == M_ROM)) busy_q <= 1'b1;
      else if (rom_go)                      busy_q <= 1'b0;
      if (go) run_q <= 1'b1;
      start_q <= go;
      int_q   <= run_q & host_set & ~cpu_clr_int;
      if (run_q & cpu_clr_int)   flag_q <= 1'b0;
      else if (set_req | emu_go) flag_q <= 1'b1;
    end
  end

  assign cpu_stall     = ~run_q;
  assign run_start     = start_q;
  assign cpu_int       = int_q;
  assign host_int_flag = flag_q;
  assign copy_start    = cstart_q;
  assign boot_addr     = BOOT_ADDR;

  AST_STALL_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> cpu_stall && !copy_start); // R1
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    armed_q |=> $stable(mode_q)); // R2
  AST_NO_INT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |=> !cpu_int); // R5
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    !cpu_stall |=> !cpu_stall); // R3
  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !run_start); // R3
  AST_COPY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |=> !copy_start); // R8
  AST_COPY_ROM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> mode_q == M_ROM); // R8
  AST_INT_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    (host_int_flag && !cpu_clr_int) |=> !cpu_int); // R6

endmodule

// File: tb/boot_stall_ctrl_tb_top.sv
module boot_stall_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RSYNC = 3;
  localparam int CW = 16;
  localparam int IB = 5;

  logic clk = 0, rst_n = 0;
  logic [1:0] boot_mode = 0;
  logic host_wr = 0, emu_req = 0, copy_done = 0, cpu_clr_int = 0;
  logic [CW-1:0] host_wdata = '0;
  logic sys_rst_n, cpu_stall, run_start, cpu_int, host_int_flag, copy_start;
  logic [31:0] boot_addr;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_stall_ctrl #(.ADDR_W(32), .CTRL_W(CW), .INT_BIT(IB), .RST_SYNC(RSYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .host_wr(host_wr),
    .host_wdata(host_wdata), .emu_req(emu_req), .copy_done(copy_done),
    .cpu_clr_int(cpu_clr_int), .sys_rst_n(sys_rst_n), .cpu_stall(cpu_stall),
    .run_start(run_start), .cpu_int(cpu_int), .host_int_flag(host_int_flag),
    .copy_start(copy_start), .boot_addr(boot_addr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic boot(logic [1:0] m);
    @(negedge clk);
    rst_n = 0; boot_mode = m;
    repeat (3) @(negedge clk);
    chk("R1 sys_rst_n", sys_rst_n, 0);
    chk("R1 stall", cpu_stall, 1);
    chk("R1 flag", host_int_flag, 0);
    chk("R1 copy_start", copy_start, 0);
    chk("R1 cpu_int", cpu_int, 0);
    rst_n = 1;
    repeat (RSYNC - 1) @(negedge clk);
    chk("R1 sync delay", sys_rst_n, 0);
    @(negedge clk);
    chk("R1 sync release", sys_rst_n, 1);
    chk("R8 no early copy_start", copy_start, 0);
    @(negedge clk);
    chk("R8 copy_start", copy_start, (m == 2'b10));
    boot_mode = ~m;
    @(negedge clk);
    chk("R8 copy_start single", copy_start, 0);
    chk("R9 boot_addr", boot_addr, 0);
  endtask

  task automatic hwrite(logic [CW-1:0] d);
    host_wr = 1; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_wdata = '0;
  endtask

  task automatic pulse_emu();
    emu_req = 1; @(negedge clk); emu_req = 0;
  endtask

  task automatic pulse_done();
    copy_done = 1; @(negedge clk); copy_done = 0;
  endtask

  task automatic clr_int();
    cpu_clr_int = 1; @(negedge clk); cpu_clr_int = 0;
  endtask

  task automatic t_host(logic [1:0] m);
    boot(m);
    repeat (4) @(negedge clk);
    chk("R3 held", cpu_stall, 1);
    hwrite(~(CW'(1) << IB));
    chk("R3 other bits no effect", cpu_stall, 1);
    pulse_emu();
    chk("R10 emu in host", cpu_stall, 1);
    pulse_done();
    chk("R10 done in host", cpu_stall, 1);
    hwrite(CW'(1) << IB);
    chk("R3 released", cpu_stall, 0);
    chk("R3 run_start", run_start, 1);
    chk("R5 no cpu_int", cpu_int, 0);
    chk("R5 flag kept", host_int_flag, 1);
    @(negedge clk);
    chk("R3 run_start once", run_start, 0);
    chk("R5 no late cpu_int", cpu_int, 0);
    hwrite(CW'(1) << IB);
    chk("R6 blocked", cpu_int, 0);
    clr_int();
    chk("R6 cleared", host_int_flag, 0);
    hwrite(CW'(1) << IB);
    chk("R6 cpu_int", cpu_int, 1);
    chk("R6 flag set", host_int_flag, 1);
    @(negedge clk);
    chk("R6 cpu_int one", cpu_int, 0);
    chk("R9 boot_addr run", boot_addr, 0);
  endtask

  task automatic t_emu_preset();
    boot(2'b01);
    pulse_done();
    chk("R10 done in emu", cpu_stall, 1);
    hwrite(CW'(1) << IB);
    chk("R4 emu flag", host_int_flag, 1);
    chk("R4 emu stalled", cpu_stall, 1);
    @(negedge clk);
    chk("R5 emu no int", cpu_int, 0);
    pulse_emu();
    chk("R7 released preset", cpu_stall, 0);
    chk("R7 flag kept", host_int_flag, 1);
    chk("R7 run_start", run_start, 1);
  endtask

  task automatic t_emu_clear();
    boot(2'b01);
    chk("R7 flag clear", host_int_flag, 0);
    pulse_emu();
    chk("R7 released", cpu_stall, 0);
    chk("R7 flag set", host_int_flag, 1);
    chk("R5 emu no int", cpu_int, 0);
  endtask

  task automatic t_rom();
    boot(2'b10);
    hwrite(CW'(1) << IB);
    chk("R4 rom flag", host_int_flag, 1);
    chk("R4 rom stalled", cpu_stall, 1);
    pulse_emu();
    chk("R10 emu in rom", cpu_stall, 1);
    repeat (5) @(negedge clk);
    chk("R8 held", cpu_stall, 1);
    pulse_done();
    chk("R8 released", cpu_stall, 0);
    chk("R8 run_start", run_start, 1);
    @(negedge clk);
    chk("R8 run_start once", run_start, 0);
  endtask

  initial begin
    t_host(2'b00);
    t_host(2'b11);
    t_emu_preset();
    t_emu_clear();
    t_rom();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule